// File: doc/BRIEF.md
# Circular Buffer Address Generator

This block produces memory addresses for eight independent circular sample buffers of a real-time filter engine. Every buffer context keeps a base address, a length in samples, a step size in address units and a running position. A configuration port loads base, length, step and addressing mode into one context. A request port names a context and asks for one post-modify access. The block returns the current address one cycle later and moves that context forward by one step. After the last slot it wraps back to the base.

Each context is a four-state machine. CTX_IDLE is the state after reset and holds until the first configuration write. CTX_LINEAR is sequential addressing. CTX_BITREV issues addresses whose offset from the base is bit-reversed over log2(length) bits, which gives FFT data ordering. CTX_FAULT is entered when a configuration is unusable. Any configuration write moves a context from any state to CTX_LINEAR, CTX_BITREV or CTX_FAULT, according to the written length and mode. Reset returns every context to CTX_IDLE. A read-back port shows, for a selected context, the address that its next access would return and whether that context is faulted.

Top module: `circbuf_agen`

## Requirements
- R1: After reset, addr_valid and req_err are 0, and every context is unconfigured. A request to an unconfigured context gives req_err=1 and addr_valid=0 in the following cycle.
- R2: A configuration write sets the context position back to its base address. rd_ptr then reads the written base, and this also holds when the write lands in the middle of a sequence.
- R3: An accepted request gives addr_valid=1 one cycle later, with addr_out equal to the address held before the request. The stored position then moves forward by one step.
- R4: The step code cfg_step selects the address increment: 2'b00 gives 1, 2'b01 gives 2, and 2'b10 or 2'b11 gives 4.
- R5: In linear mode, a buffer of length L and step S issues base, base+S, ... base+(L-1)*S and then base again.
- R6: A request or configuration write to one context leaves the position of every other context unchanged.
- R7: With cfg_brev=1 and a power-of-two length L=2^k, access number j (counting from 0) returns base + rev_k(j mod L)*S. Here rev_k reverses the low k bits.
- R8: A length of 0, or cfg_brev=1 with a length that is not a power of two, puts the context in the fault state. rd_fault then reads 1, and requests to it give req_err=1 and no address. A later valid configuration clears the fault.
- R9: When a configuration write and a request target the same context in the same cycle, the request uses the new configuration. It returns the new base, and the next access returns base+S.
- R10: In a cycle without a request, addr_valid and req_err are 0 in the next cycle, and no position changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Context selected for configuration |
| cfg_base | input | 16 | Base address |
| cfg_len | input | 8 | Buffer length in samples |
| cfg_step | input | 2 | Step code (00=1, 01=2, 1x=4) |
| cfg_brev | input | 1 | Bit-reversed addressing mode |
| req_valid | input | 1 | Access request |
| req_sel | input | 3 | Context selected for access |
| rd_sel | input | 3 | Context selected for read-back |
| addr_valid | output | 1 | addr_out carries an issued address |
| addr_out | output | 16 | Issued (pre-update) address |
| req_err | output | 1 | Last request targeted an idle or faulted context |
| rd_ptr | output | 16 | Next address of the read-back context |
| rd_fault | output | 1 | Read-back context is in the fault state |

## Verification
A configuration write and an access request can arrive in the same cycle, either at the same context or at two different ones. The bench provokes both cases. It drives both strobes together on one context, in the middle of an ongoing sequence, and judges the result by the returned address (it must be the freshly written base) and by the address that follows. It also pairs a write to one context with a request to another and checks that the request advances normally while the written context restarts at its base.

// File: rtl/cbag_pkg.sv
package cbag_pkg;

    typedef enum logic [1:0] {
        CTX_IDLE   = 2'd0,
        CTX_LINEAR = 2'd1,
        CTX_BITREV = 2'd2,
        CTX_FAULT  = 2'd3
    } ctx_state_t;

    // Step code to left-shift amount: 00 -> x1, 01 -> x2, 1x -> x4
    function automatic logic [1:0] step_shift(input logic [1:0] code);
        logic [1:0] sh;
        unique case (code)
            2'b00:   sh = 2'd0;
            2'b01:   sh = 2'd1;
            default: sh = 2'd2;
        endcase
        return sh;
    endfunction

endpackage

// File: rtl/cbag_bitrev.sv
module cbag_bitrev #(
    parameter int W = 8,
    localparam int LGW = $clog2(W + 1)
) (
    input  logic [W-1:0]   val,
    input  logic [LGW-1:0] lg,
    output logic [W-1:0]   res
);
    logic [W-1:0] full;

    always_comb begin
        for (int i = 0; i < W; i++) begin
            full[i] = val[W-1-i];
        end
        res = full >> (W - int'(lg));
    end
endmodule

// File: rtl/cbag_ctx.sv
module cbag_ctx
    import cbag_pkg::*;
#(
    parameter int AW   = 16,
    parameter int LENW = 8,
    localparam int LGW = $clog2(LENW + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_hit,
    input  logic [AW-1:0]   cfg_base,
    input  logic [LENW-1:0] cfg_len,
    input  logic [1:0]      cfg_step,
    input  logic            cfg_brev,
    input  logic            req_hit,
    output logic [AW-1:0]   cur_addr,
    output logic            served,
    output logic            faulted
);
    ctx_state_t      state_q, state_nxt;
    logic [AW-1:0]   base_q, e_base;
    logic [LENW-1:0] len_q, e_len;
    logic [1:0]      sh_q, e_sh;
    logic [LENW-1:0] idx_q, e_idx, idx_nxt;
    logic            len_pow2;
    logic [LGW-1:0]  lg;
    logic [LENW-1:0] rev_idx, off;
    logic [LENW+1:0] off_w;

    assign len_pow2 = ((cfg_len & (cfg_len - 1'b1)) == '0);

    // Next-state logic: a configuration write classifies the new setup
    always_comb begin
        state_nxt = state_q;
        if (cfg_hit) begin
            if (cfg_len == '0)
                state_nxt = CTX_FAULT;
            else if (cfg_brev)
                state_nxt = len_pow2 ? CTX_BITREV : CTX_FAULT;
            else
                state_nxt = CTX_LINEAR;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CTX_IDLE;
        else        state_q <= state_nxt;
    end

    // Effective view for this cycle: a same-cycle write is seen by the request
    always_comb begin
        e_base = cfg_hit ? cfg_base : base_q;
        e_len  = cfg_hit ? cfg_len : len_q;
        e_sh   = cfg_hit ? step_shift(cfg_step) : sh_q;
        e_idx  = cfg_hit ? '0 : idx_q;
        lg     = '0;
        for (int i = 0; i < LENW; i++) begin
            if (e_len[i]) lg = LGW'(i);
        end
    end

    cbag_bitrev #(.W(LENW)) u_rev (.val(e_idx), .lg(lg), .res(rev_idx));

    // Output process
    always_comb begin
        served = 1'b0;
        off    = e_idx;
        unique case (state_nxt)
            CTX_IDLE, CTX_FAULT: served = 1'b0;
            CTX_LINEAR:          served = 1'b1;
            CTX_BITREV: begin
                served = 1'b1;
                off    = rev_idx;
            end
        endcase
        off_w    = {2'b00, off} << e_sh;
        cur_addr = e_base + AW'(off_w);
        faulted  = (state_q == CTX_FAULT);
        idx_nxt  = e_idx;
        if (req_hit && served) begin
            idx_nxt = (({1'b0, e_idx} + 1'b1) == {1'b0, e_len}) ? '0 : e_idx + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            len_q  <= '0;
            sh_q   <= '0;
            idx_q  <= '0;
        end else begin
            if (cfg_hit) begin
                base_q <= cfg_base;
                len_q  <= cfg_len;
                sh_q   <= step_shift(cfg_step);
            end
            idx_q <= idx_nxt;
        end
    end

    assert_idx_in_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CTX_LINEAR || state_q == CTX_BITREV) |-> (idx_q < len_q));

    assert_cfg_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_hit && !req_hit) |=> (idx_q == '0));

    assert_req_moves_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_hit && !cfg_hit && served && len_q != 1) |=> (idx_q != $past(idx_q)));

    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_hit && !cfg_hit) |=> ($stable(idx_q) && $stable(state_q)));
endmodule

// File: rtl/circbuf_agen.sv
module circbuf_agen #(
    parameter int NBUF = 8,
    parameter int AW   = 16,
    parameter int LENW = 8,
    localparam int SELW = $clog2(NBUF)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_we,
    input  logic [SELW-1:0] cfg_sel,
    input  logic [AW-1:0]   cfg_base,
    input  logic [LENW-1:0] cfg_len,
    input  logic [1:0]      cfg_step,
    input  logic            cfg_brev,
    input  logic            req_valid,
    input  logic [SELW-1:0] req_sel,
    input  logic [SELW-1:0] rd_sel,
    output logic            addr_valid,
    output logic [AW-1:0]   addr_out,
    output logic            req_err,
    output logic [AW-1:0]   rd_ptr,
    output logic            rd_fault
);
    logic [AW-1:0]   addr_a [NBUF];
    logic [NBUF-1:0] served_a;
    logic [NBUF-1:0] fault_a;
    logic            sel_ok, hit_ok;

    for (genvar g = 0; g < NBUF; g++) begin : g_ctx
        cbag_ctx #(.AW(AW), .LENW(LENW)) u_ctx (
            .clk      (clk),
            .rst_n    (rst_n),
            .cfg_hit  (cfg_we && cfg_sel == SELW'(g)),
            .cfg_base (cfg_base),
            .cfg_len  (cfg_len),
            .cfg_step (cfg_step),
            .cfg_brev (cfg_brev),
            .req_hit  (req_valid && req_sel == SELW'(g)),
            .cur_addr (addr_a[g]),
            .served   (served_a[g]),
            .faulted  (fault_a[g])
        );
    end

    assign sel_ok   = (int'(req_sel) < NBUF);
    assign hit_ok   = sel_ok && served_a[req_sel];
    assign rd_ptr   = addr_a[rd_sel];
    assign rd_fault = fault_a[rd_sel];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_valid <= 1'b0;
            req_err    <= 1'b0;
            addr_out   <= '0;
        end else begin
            addr_valid <= req_valid && hit_ok;
            req_err    <= req_valid && !hit_ok;
            if (req_valid && hit_ok) addr_out <= addr_a[req_sel];
        end
    end

    assert_valid_err_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(addr_valid && req_err));

    assert_quiet_no_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!addr_valid && !req_err));

    assert_addr_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_valid |=> (addr_valid || $stable(addr_out)));
endmodule

// File: tb/circbuf_agen_bench.sv
module circbuf_agen_bench;
    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic        v;
        logic        e;
        logic [15:0] a;
        string       tag;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_sel = '0;
    logic [15:0] cfg_base = '0;
    logic [7:0]  cfg_len = '0;
    logic [1:0]  cfg_step = '0;
    logic        cfg_brev = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_sel = '0;
    logic [2:0]  rd_sel = '0;
    logic        addr_valid, req_err, rd_fault;
    logic [15:0] addr_out, rd_ptr;

    int total = 0;
    int bad = 0;
    item_t q[$];

    int m_base[8], m_len[8], m_sh[8], m_st[8], m_idx[8];

    circbuf_agen u_circbuf_agen (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_base(cfg_base), .cfg_len(cfg_len), .cfg_step(cfg_step),
        .cfg_brev(cfg_brev), .req_valid(req_valid), .req_sel(req_sel),
        .rd_sel(rd_sel), .addr_valid(addr_valid), .addr_out(addr_out),
        .req_err(req_err), .rd_ptr(rd_ptr), .rd_fault(rd_fault)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic int rev_bits(int v, int lg);
        int r = 0;
        for (int i = 0; i < lg; i++) r |= ((v >> i) & 1) << (lg - 1 - i);
        return r;
    endfunction

    function automatic int log2_of(int l);
        int r = 0;
        for (int i = 0; i < 8; i++) if ((l >> i) & 1) r = i;
        return r;
    endfunction

    function automatic int model_addr(int b);
        int off = m_idx[b];
        if (m_st[b] == 2) off = rev_bits(m_idx[b], log2_of(m_len[b]));
        return (m_base[b] + (off << m_sh[b])) & 16'hFFFF;
    endfunction

    task automatic check(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // Driver: one cycle of stimulus, expectation pushed for the monitor
    task automatic cycle(bit cw, int cs, int cb, int cl, int cst, bit crev,
                         bit rv, int rs, string tag);
        item_t it;
        @(negedge clk);
        cfg_we = cw; cfg_sel = 3'(cs); cfg_base = 16'(cb); cfg_len = 8'(cl);
        cfg_step = 2'(cst); cfg_brev = crev; req_valid = rv; req_sel = 3'(rs);
        if (cw) begin
            m_base[cs] = cb; m_len[cs] = cl; m_idx[cs] = 0;
            m_sh[cs] = (cst == 0) ? 0 : (cst == 1) ? 1 : 2;
            if (cl == 0) m_st[cs] = 3;
            else if (crev) m_st[cs] = ((cl & (cl - 1)) == 0) ? 2 : 3;
            else m_st[cs] = 1;
        end
        it.tag = tag; it.v = 0; it.e = 0; it.a = '0;
        if (rv) begin
            if (m_st[rs] == 1 || m_st[rs] == 2) begin
                it.v = 1; it.a = 16'(model_addr(rs));
                m_idx[rs] = (m_idx[rs] + 1 == m_len[rs]) ? 0 : m_idx[rs] + 1;
            end else begin
                it.e = 1;
            end
        end
        q.push_back(it);
    endtask

    task automatic cfg(int s, int b, int l, int st, bit rv_mode, string tag);
        cycle(1, s, b, l, st, rv_mode, 0, 0, tag);
    endtask

    task automatic req(int s, string tag);
        cycle(0, 0, 0, 0, 0, 0, 1, s, tag);
    endtask

    task automatic check_ptr(int s, int exp, string tag);
        cycle(0, 0, 0, 0, 0, 0, 0, 0, tag);
        rd_sel = 3'(s);
        #1;
        check(tag, rd_ptr, exp);
    endtask

    task automatic check_fault(int s, bit exp, string tag);
        cycle(0, 0, 0, 0, 0, 0, 0, 0, tag);
        rd_sel = 3'(s);
        #1;
        check(tag, rd_fault, exp);
    endtask

    // Monitor: compares results produced after each edge
    always @(posedge clk) begin
        item_t it;
        #1;
        if (q.size() != 0) begin
            it = q.pop_front();
            check({it.tag, " valid"}, addr_valid, it.v);
            check({it.tag, " err"}, req_err, it.e);
            if (it.v) check({it.tag, " addr"}, addr_out, it.a);
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) begin
            m_base[i] = 0; m_len[i] = 0; m_sh[i] = 0; m_st[i] = 0; m_idx[i] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        check("R1 reset valid", addr_valid, 0);
        check("R1 reset err", req_err, 0);
        check("R1 reset fault", rd_fault, 0);
        req(3, "R1 unconfigured request");

        // R2/R3/R5: linear, step 1, length 5
        cfg(0, 'h100, 5, 0, 0, "R2 cfg buf0");
        check_ptr(0, 'h100, "R2 ptr at base");
        for (int i = 0; i < 7; i++) req(0, "R3 R5 linear wrap buf0");
        check_ptr(0, 'h102, "R5 ptr after wrap");

        // R4: step codes 01 and 11
        cfg(1, 'h200, 3, 1, 0, "R4 cfg buf1");
        for (int i = 0; i < 4; i++) req(1, "R4 step2 buf1");
        cfg(2, 'h300, 2, 3, 0, "R4 cfg buf2");
        for (int i = 0; i < 3; i++) req(2, "R4 step4 buf2");
        check_ptr(2, 'h304, "R4 ptr step4");
        // R6: buf0 untouched by the above
        check_ptr(0, 'h102, "R6 buf0 unchanged");

        // R7: bit-reversed, length 8 step 1 and length 4 step 4
        cfg(3, 'h400, 8, 0, 1, "R7 cfg buf3");
        for (int i = 0; i < 9; i++) req(3, "R7 bitrev len8");
        cfg(4, 'h500, 4, 2, 1, "R7 cfg buf4");
        for (int i = 0; i < 4; i++) req(4, "R7 bitrev len4 step4");
        check_ptr(3, 'h404, "R7 ptr bitrev");

        // R8: fault cases and recovery
        cfg(5, 'h600, 6, 0, 1, "R8 cfg buf5 bad");
        check_fault(5, 1, "R8 fault bitrev len6");
        req(5, "R8 faulted request");
        cfg(6, 'h700, 0, 0, 0, "R8 cfg buf6 len0");
        check_fault(6, 1, "R8 fault len0");
        req(6, "R8 len0 request");
        cfg(5, 'h600, 6, 0, 0, "R8 cfg buf5 good");
        check_fault(5, 0, "R8 fault cleared");
        req(5, "R8 request after recovery");

        // R2: reconfiguration mid-sequence
        req(1, "R2 buf1 advance");
        cfg(1, 'h280, 3, 0, 0, "R2 reconfig buf1");
        check_ptr(1, 'h280, "R2 ptr back to base");

        // R9: same-cycle config and request on one context
        req(0, "R9 buf0 before");
        cycle(1, 0, 'h800, 4, 1, 0, 1, 0, "R9 collision");
        req(0, "R9 follow-up");
        check_ptr(0, 'h804, "R9 ptr after collision");
        // R6/R9: config to one context, request to another
        cycle(1, 2, 'h900, 3, 0, 0, 1, 0, "R6 split cfg/req");
        check_ptr(2, 'h900, "R6 buf2 restarted");
        check_ptr(0, 'h806, "R6 buf0 advanced");

        // R10: idle cycles change nothing
        for (int i = 0; i < 3; i++) cycle(0, 0, 0, 0, 0, 0, 0, 0, "R10 idle");
        check_ptr(0, 'h806, "R10 ptr held");

        cycle(0, 0, 0, 0, 0, 0, 0, 0, "drain");
        @(posedge clk);
        #2;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule